// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside the fetch unit and remembers, for taken branches seen recently in loop and branch code, the first instruction words found at each branch's target. When fetch presents the address of a branch it has met before, the block returns a packet of up to four target instructions. Fetch can therefore fill its queue a cycle earlier than an instruction-cache read would allow. The block does not predict target addresses or branch directions, and it is not an instruction cache.

The store is set-associative, 32 sets of 4 ways by default, 128 entries in all. Each entry holds an address tag, a valid bit, the target words and a count of how many of those words are usable. Lookups follow a valid/ready handshake. An accepted lookup produces exactly one response on the following cycle. That response stays on the outputs until it is taken: while `rsp_valid` is high and `rsp_ready` is low, `lk_ready` is low and new lookups wait. Updates come from branch resolution and are accepted in every cycle. A single invalidate input empties the whole store in one cycle.

Top module: `btic`

## Requirements
- R1: After reset `rsp_valid` is low, `lk_ready` is high, and every lookup misses until an update has been written.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. On the next cycle `rsp_valid` is high, and for a stored entry `rsp_hit` is 1 and `rsp_words` and `rsp_count` carry the stored words and count. Word 0 sits in bits [31:0]. The set index is address bits [8:4] and the tag is bits [31:9]. Bits [3:0] have no effect.
- R3: A lookup that misses returns `rsp_hit` = 0 with `rsp_count` = 0 and `rsp_words` = 0.
- R4: `lk_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values.
- R5: An update whose tag is already valid in its set rewrites that way, so a tag is never stored twice in one set.
- R6: An update to a set with no matching tag fills the lowest-numbered invalid way, if the set has one.
- R7: When a set is full, the victim comes from a 3-bit tree pseudo-LRU per set. The bits are n0 (root), n1 (ways 0/1) and n2 (ways 2/3), and a 0 selects the lower half. Touching way w sets n0 = (w<2); it sets n1 = (w==0) when w<2, or n2 = (w==2) otherwise. Hits and updates both touch the tree. The victim is chosen from the state at the start of the cycle. When a hit and an update fall in the same cycle, the update's touch is applied after the hit's.
- R8: `inv_all` clears every entry in one cycle. An update in the same cycle is dropped, and a lookup accepted in the same cycle misses.
- R9: A lookup accepted in the same cycle as an update sees the contents from before that update.
- R10: An update count above 4 is stored as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_addr | input | 32 | Branch fetch address to look up |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_words | output | 128 | Target instruction words, word 0 lowest |
| rsp_count | output | 3 | Number of usable words (0 on miss) |
| upd_valid | input | 1 | Write/allocate request |
| upd_addr | input | 32 | Branch address to store |
| upd_words | input | 128 | Target instruction words to store |
| upd_count | input | 3 | Usable word count to store |
| inv_all | input | 1 | Clear every entry |

## Verification
Directed cases fill one set with four tags and then add a fifth. The evicted way must be the one the tree state predicts, which separates true pseudo-LRU from first-way or round-robin choices. A rewrite of an existing tag is checked against the duplicate-copy failure. Same-cycle update-plus-lookup and invalidate-plus-update cases separate old-data and priority behaviour from their opposites. Held back-pressure checks that the response stays put. A long seeded random phase draws few tags and few hot sets, so hits, rewrites and evictions interleave with stalls. Each response is compared with a bench model of the tag store and tree.

// File: rtl/btic_pkg.sv
package btic_pkg;
  // How the update path picked its destination way
  typedef enum logic [1:0] {
    PICK_MATCH = 2'd0,
    PICK_FREE  = 2'd1,
    PICK_LRU   = 2'd2
  } pick_e;
endpackage

// File: rtl/btic_match.sv
module btic_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAYS-1:0]          ways_valid,
  input  logic [WAYS*TAG_W-1:0]    ways_tag,
  input  logic [TAG_W-1:0]         probe,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = ways_valid[g] && (ways_tag[g*TAG_W +: TAG_W] == probe);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = 0; w < WAYS; w++)
      if (eq[w]) way = WAY_W'(w);
  end

  // R5: rewrite policy means a tag is never present twice in a set
  assert_single_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eq));
endmodule

// File: rtl/btic_plru.sv
module btic_plru #(
  parameter int SETS = 32,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  vic_set,
  output logic [$clog2(WAYS)-1:0]  vic_way,
  input  logic                     ta_en,
  input  logic [$clog2(SETS)-1:0]  ta_set,
  input  logic [$clog2(WAYS)-1:0]  ta_way,
  input  logic                     tb_en,
  input  logic [$clog2(SETS)-1:0]  tb_set,
  input  logic [$clog2(WAYS)-1:0]  tb_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] st_q [SETS];
  logic [NODES-1:0] nxt_a, base_b, nxt_b;

  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] s);
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++)
      node = node * 2 + (s[node-1] ? 1 : 0);
    return WAY_W'(node - WAYS);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] s,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int leaf, child, node;
    r    = s;
    leaf = WAYS + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      child = leaf >> l;
      node  = leaf >> (l + 1);
      r[node-1] = ~child[0];
    end
    return r;
  endfunction

  always_comb begin
    vic_way = pick(st_q[vic_set]);
    nxt_a   = touch(st_q[ta_set], ta_way);
    base_b  = (ta_en && (ta_set == tb_set)) ? nxt_a : st_q[tb_set];
    nxt_b   = touch(base_b, tb_way);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (ta_en) st_q[ta_set] <= nxt_a;
      if (tb_en) st_q[tb_set] <= nxt_b;
    end
  end
endmodule

// File: rtl/btic.sv
module btic #(
  parameter int AW    = 32,
  parameter int IW    = 32,
  parameter int WORDS = 4,
  parameter int SETS  = 32,
  parameter int WAYS  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_valid,
  output logic                           lk_ready,
  input  logic [AW-1:0]                  lk_addr,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic                           rsp_hit,
  output logic [WORDS*IW-1:0]            rsp_words,
  output logic [$clog2(WORDS+1)-1:0]     rsp_count,
  input  logic                           upd_valid,
  input  logic [AW-1:0]                  upd_addr,
  input  logic [WORDS*IW-1:0]            upd_words,
  input  logic [$clog2(WORDS+1)-1:0]     upd_count,
  input  logic                           inv_all
);
  import btic_pkg::*;

  localparam int DW    = WORDS * IW;
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam int OFF_W = $clog2(WORDS * (IW / 8));
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = AW - OFF_W - IDX_W;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [DW-1:0]    data_q [SETS][WAYS];
  logic [CNT_W-1:0] cnt_q  [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS*TAG_W-1:0] lk_tags, up_tags;
  logic             lk_match, up_match, lk_fire, hit_eff, upd_do;
  logic [WAY_W-1:0] lk_way, up_mway, vic_way, free_way, up_way;
  logic             free_any, any_valid;
  logic [CNT_W-1:0] up_cnt;
  pick_e            pick;
  logic             unused_low;

  assign lk_idx = lk_addr[OFF_W +: IDX_W];
  assign lk_tag = lk_addr[AW-1 -: TAG_W];
  assign up_idx = upd_addr[OFF_W +: IDX_W];
  assign up_tag = upd_addr[AW-1 -: TAG_W];
  assign unused_low = ^{lk_addr[OFF_W-1:0], upd_addr[OFF_W-1:0]};

  for (genvar g = 0; g < WAYS; g++) begin : g_tags
    assign lk_tags[g*TAG_W +: TAG_W] = tag_q[lk_idx][g];
    assign up_tags[g*TAG_W +: TAG_W] = tag_q[up_idx][g];
  end

  btic_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .ways_valid(valid_q[lk_idx]), .ways_tag(lk_tags),
    .probe(lk_tag), .hit(lk_match), .way(lk_way));

  btic_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .clk(clk), .rst_n(rst_n), .ways_valid(valid_q[up_idx]), .ways_tag(up_tags),
    .probe(up_tag), .hit(up_match), .way(up_mway));

  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign hit_eff  = lk_fire && lk_match && !inv_all;
  assign upd_do   = upd_valid && !inv_all;
  assign up_cnt   = (upd_count > CNT_W'(WORDS)) ? CNT_W'(WORDS) : upd_count;

  // lowest-numbered invalid way of the update set
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[up_idx][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (up_match)      pick = PICK_MATCH;
    else if (free_any) pick = PICK_FREE;
    else               pick = PICK_LRU;
    case (pick)
      PICK_MATCH: up_way = up_mway;
      PICK_FREE:  up_way = free_way;
      default:    up_way = vic_way;
    endcase
  end

  btic_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .vic_set(up_idx), .vic_way(vic_way),
    .ta_en(hit_eff), .ta_set(lk_idx), .ta_way(lk_way),
    .tb_en(upd_do),  .tb_set(up_idx), .tb_way(up_way));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (inv_all) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (upd_do) begin
      valid_q[up_idx][up_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_do) begin
      tag_q[up_idx][up_way]  <= up_tag;
      data_q[up_idx][up_way] <= upd_words;
      cnt_q[up_idx][up_way]  <= up_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_words <= '0;
      rsp_count <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit_eff;
      rsp_words <= hit_eff ? data_q[lk_idx][lk_way] : '0;
      rsp_count <= hit_eff ? cnt_q[lk_idx][lk_way] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
                                $stable(rsp_words) && $stable(rsp_count));
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_count == '0 && rsp_words == '0);
  assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_count <= CNT_W'(WORDS));
  assert_inv_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && lk_fire |=> !rsp_hit);
  assert_inv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid);
endmodule

// File: tb/btic_bench.sv
module btic_bench;
  localparam int AW = 32, IW = 32, WORDS = 4, SETS = 32, WAYS = 4, CNT_W = 3;
  localparam int DW = WORDS * IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, rsp_ready = 1'b0, upd_valid = 1'b0, inv_all = 1'b0;
  logic [AW-1:0] lk_addr = '0, upd_addr = '0;
  logic [DW-1:0] upd_words = '0;
  logic [CNT_W-1:0] upd_count = '0;
  logic lk_ready, rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_words;
  logic [CNT_W-1:0] rsp_count;

  always #5 clk = ~clk;

  btic #(.AW(AW), .IW(IW), .WORDS(WORDS), .SETS(SETS), .WAYS(WAYS)) u_btic (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_words(rsp_words), .rsp_count(rsp_count),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_words(upd_words),
    .upd_count(upd_count), .inv_all(inv_all));

  int checks = 0, errors = 0;
  bit done = 0;

  bit            m_val [SETS][WAYS];
  logic [22:0]   m_tag [SETS][WAYS];
  logic [DW-1:0] m_dat [SETS][WAYS];
  int            m_cnt [SETS][WAYS];
  logic [2:0]    m_pl  [SETS];
  bit            e_rv, e_hit;
  logic [DW-1:0] e_w;
  int            e_c;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int vict(input logic [2:0] p);
    if (!p[0]) return p[1] ? 1 : 0;
    return p[2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] tch(input logic [2:0] p, input int w);
    logic [2:0] r;
    r = p;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  function automatic logic [DW-1:0] rwords();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] mk(input int tag, input int set);
    return {23'(tag), 5'(set), 4'($urandom)};
  endfunction

  // One cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input bit lv, input logic [31:0] la, input bit rr,
                      input bit uv, input logic [31:0] ua, input logic [DW-1:0] uw,
                      input int uc, input bit inv, input string req);
    bit acc, found, umatch;
    int ls, us, hw, uway;
    logic [22:0] lt, ut;
    lk_valid = lv; lk_addr = la; rsp_ready = rr;
    upd_valid = uv; upd_addr = ua; upd_words = uw; upd_count = CNT_W'(uc);
    inv_all = inv;
    #1;
    chk(lk_ready == (!e_rv || rr), "R4", "lk_ready", DW'(lk_ready), DW'(!e_rv || rr));
    acc = lv && (!e_rv || rr);
    @(posedge clk);
    ls = int'(la[8:4]); lt = la[31:9];
    us = int'(ua[8:4]); ut = ua[31:9];
    found = 0; hw = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_val[ls][w] && m_tag[ls][w] == lt) begin found = 1; hw = w; end
    if (inv) found = 0;
    // update destination from start-of-cycle state
    umatch = 0; uway = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_val[us][w] && m_tag[us][w] == ut) begin umatch = 1; uway = w; end
    if (!umatch)
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[us][w]) uway = w;
    if (uway < 0) uway = vict(m_pl[us]);
    if (acc) begin
      e_rv = 1; e_hit = found;
      e_w = found ? m_dat[ls][hw] : '0;
      e_c = found ? m_cnt[ls][hw] : 0;
      if (found) m_pl[ls] = tch(m_pl[ls], hw);
    end else if (rr) begin
      e_rv = 0;
    end
    if (inv) begin
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
    end else if (uv) begin
      m_val[us][uway] = 1; m_tag[us][uway] = ut; m_dat[us][uway] = uw;
      m_cnt[us][uway] = (uc > WORDS) ? WORDS : uc;
      m_pl[us] = tch(m_pl[us], uway);
    end
    @(negedge clk);
    chk(rsp_valid == e_rv, req, "rsp_valid", DW'(rsp_valid), DW'(e_rv));
    if (e_rv) begin
      chk(rsp_hit == e_hit, req, "rsp_hit", DW'(rsp_hit), DW'(e_hit));
      chk(int'(rsp_count) == e_c, req, "rsp_count", DW'(rsp_count), DW'(e_c));
      chk(rsp_words == e_w, req, "rsp_words", rsp_words, e_w);
    end
  endtask

  task automatic look(input logic [31:0] a, input string req);
    step(1, a, 1, 0, '0, '0, 0, 0, req);
  endtask

  task automatic put(input logic [31:0] a, input int c, input string req);
    step(0, '0, 1, 1, a, rwords(), c, 0, req);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h0B71C);
    for (int s = 0; s < SETS; s++) begin
      m_pl[s] = '0;
      for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
    end
    e_rv = 0; e_hit = 0; e_w = '0; e_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", DW'(rsp_valid), '0);
    chk(lk_ready == 1'b1, "R1", "lk_ready after reset", DW'(lk_ready), DW'(1));
    look(mk(7, 3), "R1");
    chk(rsp_hit == 1'b0, "R1", "hit on empty store", DW'(rsp_hit), '0);
    // R2: store then look up, different offset bits
    put({23'd7, 5'd3, 4'h0}, 4, "R2");
    look({23'd7, 5'd3, 4'hC}, "R2");
    chk(rsp_hit == 1'b1, "R2", "hit after write", DW'(rsp_hit), DW'(1));
    // R3: same set, other tag misses
    look({23'd8, 5'd3, 4'h0}, "R3");
    // R9: update and lookup of the same address in one cycle
    step(1, {23'd9, 5'd3, 4'h0}, 1, 1, {23'd9, 5'd3, 4'h0}, rwords(), 2, 0, "R9");
    chk(rsp_hit == 1'b0, "R9", "same-cycle lookup sees old", DW'(rsp_hit), '0);
    look({23'd9, 5'd3, 4'h0}, "R9");
    // R5: rewrite of an existing tag
    put({23'd7, 5'd3, 4'h0}, 3, "R5");
    look({23'd7, 5'd3, 4'h4}, "R5");
    // R6 and R7: fill set 10, touch, then evict
    put(mk(1, 10), 1, "R6");
    put(mk(2, 10), 2, "R6");
    put(mk(3, 10), 3, "R6");
    put(mk(4, 10), 4, "R6");
    look(mk(1, 10), "R7");
    look(mk(3, 10), "R7");
    put(mk(5, 10), 4, "R7");
    for (int t = 1; t <= 5; t++) look(mk(t, 10), "R7");
    put(mk(6, 10), 2, "R7");
    for (int t = 1; t <= 6; t++) look(mk(t, 10), "R7");
    // R7: hit and update in the same set and cycle
    step(1, mk(1, 10), 1, 1, mk(11, 10), rwords(), 1, 0, "R7");
    for (int t = 1; t <= 11; t++) look(mk(t, 10), "R7");
    // R10: count clamp
    put(mk(20, 12), 7, "R10");
    look(mk(20, 12), "R10");
    chk(rsp_count == 3'd4, "R10", "clamped count", DW'(rsp_count), DW'(4));
    // R4: back-pressure hold
    step(1, mk(20, 12), 0, 0, '0, '0, 0, 0, "R4");
    repeat (3) step(1, mk(7, 3), 0, 0, '0, '0, 0, 0, "R4");
    step(1, mk(7, 3), 1, 0, '0, '0, 0, 0, "R4");
    step(0, '0, 1, 0, '0, '0, 0, 0, "R4");
    // R8: invalidate with same-cycle update and lookup
    step(1, mk(20, 12), 1, 1, mk(30, 14), rwords(), 2, 1, "R8");
    chk(rsp_hit == 1'b0, "R8", "lookup during invalidate", DW'(rsp_hit), '0);
    look(mk(30, 14), "R8");
    look(mk(20, 12), "R8");
    look(mk(7, 3), "R8");
    // seeded random phase over few tags and hot sets
    for (int i = 0; i < 4000; i++) begin
      int sa, su;
      sa = ($urandom % 3 == 0) ? int'($urandom % SETS) : (($urandom % 2) ? 5 : 9);
      su = ($urandom % 3 == 0) ? int'($urandom % SETS) : (($urandom % 2) ? 5 : 9);
      step($urandom % 4 != 0, mk(int'($urandom % 7), sa), $urandom % 4 != 0,
           $urandom % 3 == 0, mk(int'($urandom % 7), su), rwords(),
           ($urandom % 8 == 0) ? 7 : int'(1 + $urandom % 4),
           $urandom % 300 == 0, "R7");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule